// File: doc/BRIEF.md
# Elastic Pipeline Buffer

This block sits between two stages of a synchronous pipeline. The data moves with a forward valid flag. A backward stop flag tells the sender that the receiver cannot take a token in this cycle. A token crosses a boundary on a clock edge only when valid is high and stop is low at that boundary. A sender that sees stop keeps its valid and data unchanged until the token has been taken.

One parameter picks the variant behind this common contract:
- **Pass-through:** stores nothing and wires the handshake straight through.
- **Double-register:** has a main slot and a spare slot, which gives one entry of slack beyond a plain register. Its stop output comes only from its own occupancy.
- **Queue:** a small circular queue of configurable depth. It soaks up bursts while the consumer stalls and empties them once the consumer resumes.

All variants run on one clock with a synchronous active-high reset. Tokens always leave in arrival order.

Top module: `elastic_buf`

## Requirements
- R1: A token is accepted at the input only in a cycle with in_vld high and in_stop low. A token leaves at the output only in a cycle with out_vld high and out_stop low. While out_stop is held high, no token leaves.
- R2: When out_vld is high and out_stop is high at a clock edge, out_vld is still high after that edge and out_data is unchanged.
- R3: Tokens leave in the order they entered, with none dropped and none repeated, under any pattern of input gaps and output stalls.
- R4: After a clock edge with rst high, the double-register and queue variants show out_vld low and in_stop low.
- R5: In the pass-through variant (MODE 0), out_vld equals in_vld, out_data equals in_data and in_stop equals out_stop within the same cycle.
- R6: In the double-register variant (MODE 1), a stalled consumer lets exactly two tokens in before in_stop rises. in_stop depends only on occupancy and never follows out_stop within a cycle.
- R7: In the queue variant (MODE 2), a stalled consumer lets exactly DEPTH tokens in before in_stop rises. The stored tokens drain in order once out_stop falls.
- R8: The number of tokens held never exceeds the variant's capacity: 0, 2 or DEPTH.
- R9: With no stall, the block moves one token per cycle. The first token appears at the output in the same cycle it is offered in MODE 0, and one cycle after acceptance in MODES 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every register |
| rst | input | 1 | Synchronous active-high reset, empties the buffer |
| in_vld | input | 1 | Upstream token present |
| in_stop | output | 1 | Buffer cannot accept this cycle |
| in_data | input | WIDTH | Upstream token payload |
| out_vld | output | 1 | Token offered downstream |
| out_stop | input | 1 | Downstream cannot accept this cycle |
| out_data | output | WIDTH | Payload of the offered token |

## Verification
The properties assume the upstream side obeys the contract. Once it raises in_vld, it keeps in_vld and in_data unchanged until a cycle where in_stop is low. In the pass-through variant, this upstream holding is what makes the output-hold property true. The stimulus keeps a hold flag that refuses to change valid or data while a token is pending. The random and directed scenarios only choose whether to offer a new token when nothing is pending. The occupancy bound is checked against a token count derived only from boundary transfers.

// File: rtl/eb_pkg.sv
package eb_pkg;

  localparam int EB_MODE_PASS = 0;
  localparam int EB_MODE_DREG = 1;
  localparam int EB_MODE_FIFO = 2;

  function automatic int eb_capacity(input int mode, input int depth);
    if (mode == EB_MODE_PASS) return 0;
    if (mode == EB_MODE_DREG) return 2;
    return depth;
  endfunction

endpackage

// File: rtl/eb_pass.sv
module eb_pass #(
  parameter int WIDTH = 16
) (
  input  logic             in_vld,
  output logic             in_stop,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_vld,
  input  logic             out_stop,
  output logic [WIDTH-1:0] out_data
);

  assign out_vld  = in_vld;
  assign out_data = in_data;
  assign in_stop  = out_stop;

endmodule

// File: rtl/eb_dreg.sv
module eb_dreg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  output logic             in_stop,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_vld,
  input  logic             out_stop,
  output logic [WIDTH-1:0] out_data
);

  logic             main_v;
  logic             spare_v;
  logic [WIDTH-1:0] main_d;
  logic [WIDTH-1:0] spare_d;

  logic take;
  logic accept;
  logic fill_main;
  logic fill_spare;
  logic promote;

  always_comb begin
    take       = main_v & ~out_stop;
    accept     = in_vld & ~spare_v;
    promote    = spare_v & take;
    fill_main  = accept & (~main_v | take);
    fill_spare = accept & main_v & ~take;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      main_v  <= 1'b0;
      spare_v <= 1'b0;
    end else begin
      if (promote) begin
        spare_v <= 1'b0;
      end else if (fill_spare) begin
        spare_v <= 1'b1;
      end
      if (fill_main) begin
        main_v <= 1'b1;
      end else if (take && !spare_v) begin
        main_v <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (promote) begin
      main_d <= spare_d;
    end else if (fill_main) begin
      main_d <= in_data;
    end
    if (fill_spare) begin
      spare_d <= in_data;
    end
  end

  assign out_vld  = main_v;
  assign out_data = main_d;
  assign in_stop  = spare_v;

endmodule

// File: rtl/eb_fifo.sv
module eb_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  output logic             in_stop,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_vld,
  input  logic             out_stop,
  output logic [WIDTH-1:0] out_data
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;
  logic [CW-1:0]    count;
  logic             wr_en;
  logic             rd_en;
  logic             full;
  logic             empty;

  always_comb begin
    full  = (count == FULL);
    empty = (count == '0);
    wr_en = in_vld & ~full;
    rd_en = ~empty & ~out_stop;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_ptr] <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) begin
        wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      end
      if (rd_en) begin
        rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      end
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign out_vld  = ~empty;
  assign out_data = mem[rd_ptr];
  assign in_stop  = full;

endmodule

// File: rtl/elastic_buf.sv
module elastic_buf
  import eb_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int MODE  = EB_MODE_FIFO,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  output logic             in_stop,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_vld,
  input  logic             out_stop,
  output logic [WIDTH-1:0] out_data
);

  generate
    if (MODE == EB_MODE_PASS) begin : g_pass
      eb_pass #(.WIDTH(WIDTH)) u_core (
        .in_vld(in_vld), .in_stop(in_stop), .in_data(in_data),
        .out_vld(out_vld), .out_stop(out_stop), .out_data(out_data)
      );
    end else if (MODE == EB_MODE_DREG) begin : g_dreg
      eb_dreg #(.WIDTH(WIDTH)) u_core (
        .clk(clk), .rst(rst),
        .in_vld(in_vld), .in_stop(in_stop), .in_data(in_data),
        .out_vld(out_vld), .out_stop(out_stop), .out_data(out_data)
      );
    end else begin : g_fifo
      eb_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_core (
        .clk(clk), .rst(rst),
        .in_vld(in_vld), .in_stop(in_stop), .in_data(in_data),
        .out_vld(out_vld), .out_stop(out_stop), .out_data(out_data)
      );
    end
  endgenerate

endmodule

// File: rtl/eb_checker.sv
module eb_checker
  import eb_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int MODE  = EB_MODE_FIFO,
  parameter int DEPTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_vld,
  input logic             in_stop,
  input logic             out_vld,
  input logic             out_stop,
  input logic [WIDTH-1:0] out_data
);

  localparam int CAP = eb_capacity(MODE, DEPTH);
  localparam int OW  = $clog2(CAP + 2) + 1;
  localparam logic [OW-1:0] CAPV = OW'(CAP);

  logic [OW-1:0] occ;
  logic          in_fire;
  logic          out_fire;

  assign in_fire  = in_vld & ~in_stop;
  assign out_fire = out_vld & ~out_stop;

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= occ + OW'(in_fire) - OW'(out_fire);
  end

  // R2: a stalled output keeps its token and payload
  p_hold_out_r2: assert property (@(posedge clk) disable iff (rst)
    (out_vld && out_stop) |=> (out_vld && $stable(out_data)));

  // R8: occupancy bound
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    occ <= CAPV);

  generate
    if (MODE == EB_MODE_PASS) begin : g_pass_chk
      // R5: handshake passes straight through
      p_pass_stop_r5: assert property (@(posedge clk) disable iff (rst)
        in_stop == out_stop);
      p_pass_vld_r5: assert property (@(posedge clk) disable iff (rst)
        out_vld == in_vld);
    end else begin : g_store_chk
      // R4: reset leaves the buffer empty and open
      p_reset_empty_r4: assert property (@(posedge clk)
        rst |=> (!out_vld && !in_stop));
      // R1: nothing is offered when no token is held
      p_empty_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (occ == '0) |-> !out_vld);
      // R6, R7: stop reflects full occupancy only
      p_stop_full_r7: assert property (@(posedge clk) disable iff (rst)
        in_stop == (occ == CAPV));
    end
  endgenerate

endmodule

bind elastic_buf eb_checker #(.WIDTH(WIDTH), .MODE(MODE), .DEPTH(DEPTH)) u_eb_checker (
  .clk(clk), .rst(rst), .in_vld(in_vld), .in_stop(in_stop),
  .out_vld(out_vld), .out_stop(out_stop), .out_data(out_data)
);

// File: tb/test_elastic_buf.sv
`timescale 1ns/1ps
module test_elastic_buf;

  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic         in_vld   [3];
  logic [W-1:0] in_data  [3];
  logic         out_stop [3];
  logic         in_stop  [3];
  logic         out_vld  [3];
  logic [W-1:0] out_data [3];

  elastic_buf #(.WIDTH(W), .MODE(0), .DEPTH(4)) i_elastic_buf_pass (
    .clk(clk), .rst(rst), .in_vld(in_vld[0]), .in_stop(in_stop[0]), .in_data(in_data[0]),
    .out_vld(out_vld[0]), .out_stop(out_stop[0]), .out_data(out_data[0]));
  elastic_buf #(.WIDTH(W), .MODE(1), .DEPTH(4)) i_elastic_buf_dreg (
    .clk(clk), .rst(rst), .in_vld(in_vld[1]), .in_stop(in_stop[1]), .in_data(in_data[1]),
    .out_vld(out_vld[1]), .out_stop(out_stop[1]), .out_data(out_data[1]));
  elastic_buf #(.WIDTH(W), .MODE(2), .DEPTH(4)) i_elastic_buf (
    .clk(clk), .rst(rst), .in_vld(in_vld[2]), .in_stop(in_stop[2]), .in_data(in_data[2]),
    .out_vld(out_vld[2]), .out_stop(out_stop[2]), .out_data(out_data[2]));

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [W-1:0] model[$];
  logic [W-1:0] next_val = 16'h1000;
  bit hold = 0;
  int n_in = 0;
  int n_out = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL R3 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  // One cycle of traffic on buffer idx; entered just after a falling edge.
  task automatic step(input int idx, input bit send, input bit stall,
                      output bit fi, output bit fo);
    if (!hold) begin
      in_vld[idx] = send;
      if (send) in_data[idx] = next_val;
    end
    out_stop[idx] = stall;
    #1;
    fi = in_vld[idx] & ~in_stop[idx];
    fo = out_vld[idx] & ~out_stop[idx];
    if (fi) begin
      model.push_back(in_data[idx]);
      next_val = next_val + 16'd1;
      n_in++;
    end
    if (fo) begin
      n_out++;
      if (model.size() == 0)
        chk(0, "R3", "token out of empty model", int'(out_data[idx]), 0);
      else
        chk(out_data[idx] == model[0], "R3", "output order",
            int'(out_data[idx]), int'(model[0]));
      if (model.size() != 0) void'(model.pop_front());
    end
    hold = in_vld[idx] & ~fi;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain(input int idx);
    bit fi, fo;
    for (int k = 0; k < 40 && (model.size() != 0 || hold); k++) step(idx, 0, 0, fi, fo);
    step(idx, 0, 0, fi, fo);
    chk(model.size() == 0 && !hold, "R3", "buffer drained", model.size(), 0);
    in_vld[idx] = 0;
    out_stop[idx] = 0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 3; i++) begin
      chk(out_vld[i] == 0, "R4", "out_vld after reset", out_vld[i], 0);
      chk(in_stop[i] == 0, "R4", "in_stop after reset", in_stop[i], 0);
    end
  endtask

  task automatic t_pass_comb();
    in_vld[0] = 1; in_data[0] = 16'hA5C3; out_stop[0] = 0; #1;
    chk(out_vld[0] == 1, "R5", "out_vld follows in_vld", out_vld[0], 1);
    chk(out_data[0] == 16'hA5C3, "R5", "data passes", out_data[0], 16'hA5C3);
    chk(in_stop[0] == 0, "R5", "stop low passes", in_stop[0], 0);
    out_stop[0] = 1; #1;
    chk(in_stop[0] == 1, "R5", "stop high passes", in_stop[0], 1);
    in_vld[0] = 0; out_stop[0] = 0; #1;
    chk(out_vld[0] == 0, "R5", "out_vld drops", out_vld[0], 0);
    @(negedge clk);
  endtask

  // R9: back-to-back tokens with no stall
  task automatic t_stream(input int idx, input int lat);
    bit fi, fo;
    for (int k = 0; k < 8 + lat; k++) begin
      step(idx, k < 8, 0, fi, fo);
      if (k < 8) chk(fi == 1, "R9", "accept every cycle", fi, 1);
      chk(fo == (k >= lat), "R9", "emit timing", fo, k >= lat);
    end
    drain(idx);
  endtask

  // R1, R2, R6, R7: fill under stall, then drain
  task automatic t_fill(input int idx, input int cap);
    bit fi, fo;
    int acc = 0;
    int outs = 0;
    logic [W-1:0] first = next_val;
    for (int k = 0; k < cap + 4; k++) begin
      step(idx, 1, 1, fi, fo);
      acc += int'(fi);
      outs += int'(fo);
      if (k > 0 && cap > 0) begin
        chk(out_vld[idx] == 1, "R2", "out_vld held in stall", out_vld[idx], 1);
        chk(out_data[idx] == first, "R2", "data held in stall",
            int'(out_data[idx]), int'(first));
      end
    end
    chk(acc == cap, (idx == 1) ? "R6" : "R7", "tokens taken while stalled", acc, cap);
    chk(outs == 0, "R1", "nothing leaves while stalled", outs, 0);
    chk(in_stop[idx] == 1, "R7", "stop raised when full", in_stop[idx], 1);
    drain(idx);
  endtask

  // R6: stop output ignores out_stop in the same cycle
  task automatic t_dreg_regstop();
    bit fi, fo;
    step(1, 1, 1, fi, fo);
    in_vld[1] = 0; hold = 0;
    out_stop[1] = 1; #1;
    chk(in_stop[1] == 0, "R6", "stop with one token, stalled", in_stop[1], 0);
    out_stop[1] = 0; #1;
    chk(in_stop[1] == 0, "R6", "stop with one token, free", in_stop[1], 0);
    out_stop[1] = 1;
    @(negedge clk);
    drain(1);
  endtask

  task automatic t_random(input int idx);
    bit fi, fo;
    n_in = 0; n_out = 0;
    for (int k = 0; k < 400; k++)
      step(idx, $urandom_range(0, 9) < 7, $urandom_range(0, 9) < 4, fi, fo);
    drain(idx);
    chk(n_in == n_out && n_in > 100, "R3", "token count conserved", n_out, n_in);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      in_vld[i] = 0; in_data[i] = '0; out_stop[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_pass_comb();
    t_stream(0, 0);
    t_stream(1, 1);
    t_stream(2, 1);
    t_fill(0, 0);
    t_fill(1, 2);
    t_fill(2, 4);
    t_dreg_regstop();
    t_random(0);
    t_random(1);
    t_random(2);
    summary();
    $finish;
  end

endmodule